// File: doc/BRIEF.md
# Opcode-Menu SPI Flash Cycle Engine

This block is a register-programmed SPI flash master that runs exactly one flash cycle each time software sets the go bit. Software does not write an opcode for each cycle. It fills an eight-entry opcode menu, a table that gives each entry a two-bit cycle type, a flash address and a 64-byte data buffer. The control word then names a menu entry, a byte count and whether a data phase follows. The engine builds the frame on the serial pins (chip select, serial clock, MOSI and MISO) in SPI mode 0.

An optional prefix opcode, such as a write-enable, can be sent as its own chip-select frame directly before the main frame. The engine stays busy from the first frame to the end of the second, so no other command can start between them. A sticky lock bit freezes the menu and the type table, which limits the engine to opcodes that are already in the menu. A speed bit selects the faster serial clock, but only when the capability input allows it. Progress is shown in a status word whose done and error flags are cleared by writing one to them.

Top module: `spi_menu_engine`

## Requirements
- R1: After reset, cs_no is 1, sck_o is 0, the status word reads 0 and the control word reads 0.
- R2: Each frame uses SPI mode 0. SCK idles low, and MOSI is sent MSB first and is valid at every SCK rising edge, where MISO is also sampled. The first byte of the main frame is the menu entry selected by control bits 6:4. Entry i is byte i of the menu: word 4 holds entries 0 to 3 and word 5 holds entries 4 to 7, with the lowest entry in bits 7:0.
- R3: Entry i takes its type from bits 2i+1:2i of the type word (word 6). The codes are 0 read without address, 1 write without address, 2 read with address and 3 write with address. For types 2 and 3, three address bytes follow the opcode, most significant byte first.
- R4: The address word (word 2) keeps only bits 23:0. Bits 31:24 of a write are dropped, both on readback and on the serial pins.
- R5: When control bit 14 is set, the data phase moves control bits 13:8 plus one bytes. A write type sends buffer bytes in increasing order from byte 0. Buffer byte j lives in word 16+j/4, at bits 8*(j mod 4)+7:8*(j mod 4).
- R6: In the data phase of a read type, MOSI sends 0x00 and each received byte is stored in buffer byte 0, 1, 2 and so on.
- R7: When control bit 14 is clear, the frame holds only the opcode and, for types 2 and 3, the address.
- R8: Status word 1 has busy in bit 0, done in bit 1 and error in bit 2. Done is set when a cycle ends. Writing 1 to done or error clears that flag, and writing 0 leaves it unchanged.
- R9: A control write with the go bit (bit 0) set while busy is 1 starts nothing, leaves the stored control fields unchanged and sets error.
- R10: With control bit 2 set, the prefix byte (word 3, bits 7:0) is sent alone in its own frame first. cs_no then stays high for at least GAP_CLKS (2) clocks before the main frame, and busy stays 1 throughout.
- R11: Control bit 15 selects an SCK half period of HALF_FAST (2) clocks when fast_ok_i is 1. Otherwise the half period is HALF_SLOW (3) clocks.
- R12: Writing 1 to bit 0 of word 7 sets a lock that only reset clears. While the lock is set, writes to words 4, 5 and 6 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 5 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational from reg_addr_i |
| fast_ok_i | input | 1 | Fast serial clock permitted |
| sck_o | output | 1 | Serial clock |
| cs_no | output | 1 | Chip select, active low |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |

## Verification
Busy reads 1 from the first clock edge after the go write. Done becomes 1 on the same edge where busy drops, so the bench polls the status word at falling clock edges and checks the frame only after busy reads 0. Frame bytes are collected at SCK rising edges, and the bench drives MISO on SCK falling edges. Each byte therefore has half an SCK period of setup. The SCK half period and the chip-select gap are measured from edge timestamps in units of the bench clock period. A sweep covers every menu entry, so every cycle type, with byte counts of 1, 4, 17 and 64.

// File: rtl/spi_menu_pkg.sv
package spi_menu_pkg;
  localparam int unsigned BUF_BYTES = 64;
  localparam int unsigned CNT_W     = $clog2(BUF_BYTES);

  localparam logic [4:0] A_CTRL    = 5'd0;
  localparam logic [4:0] A_STAT    = 5'd1;
  localparam logic [4:0] A_ADDR    = 5'd2;
  localparam logic [4:0] A_PREFIX  = 5'd3;
  localparam logic [4:0] A_MENU_LO = 5'd4;
  localparam logic [4:0] A_MENU_HI = 5'd5;
  localparam logic [4:0] A_TYPES   = 5'd6;
  localparam logic [4:0] A_LOCK    = 5'd7;
  localparam logic [4:0] A_BUF0    = 5'd16;

  typedef struct packed {
    logic             fast;
    logic             den;
    logic [CNT_W-1:0] cnt_m1;
    logic [2:0]       idx;
    logic             atom;
  } cmd_t;

  typedef enum logic [1:0] {PH_PRE, PH_OP, PH_ADDR, PH_DATA} phase_e;
endpackage

// File: rtl/spi_menu_regs.sv
module spi_menu_regs
  import spi_menu_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [4:0]       addr_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o,
  input  logic             seq_busy_i,
  input  logic             done_set_i,
  input  logic             buf_we_i,
  input  logic [CNT_W-1:0] buf_idx_i,
  input  logic [7:0]       buf_wdata_i,
  output logic [7:0]       buf_rdata_o,
  output logic             start_o,
  output cmd_t             cmd_o,
  output logic [23:0]      faddr_o,
  output logic [7:0]       prefix_o,
  output logic [63:0]      menu_o,
  output logic [15:0]      types_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic             lock_o
);
  cmd_t        cmd_q;
  logic        start_q, done_q, err_q, lock_q;
  logic [23:0] faddr_q;
  logic [7:0]  prefix_q;
  logic [63:0] menu_q;
  logic [15:0] types_q;
  logic [7:0]  buf_q [BUF_BYTES];

  assign busy_o = seq_busy_i | start_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q    <= '0;
      start_q  <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      lock_q   <= 1'b0;
      faddr_q  <= '0;
      prefix_q <= '0;
      menu_q   <= '0;
      types_q  <= '0;
      for (int i = 0; i < BUF_BYTES; i++) buf_q[i] <= '0;
    end else begin
      start_q <= 1'b0;
      if (we_i && addr_i == A_STAT) begin
        if (wdata_i[1]) done_q <= 1'b0;
        if (wdata_i[2]) err_q  <= 1'b0;
      end
      if (done_set_i) done_q <= 1'b0 | 1'b1;
      if (we_i && addr_i == A_CTRL) begin
        if (busy_o) begin
          if (wdata_i[0]) err_q <= 1'b1;
        end else begin
          cmd_q.fast   <= wdata_i[15];
          cmd_q.den    <= wdata_i[14];
          cmd_q.cnt_m1 <= wdata_i[13:8];
          cmd_q.idx    <= wdata_i[6:4];
          cmd_q.atom   <= wdata_i[2];
          start_q      <= wdata_i[0];
        end
      end
      if (we_i && addr_i == A_ADDR)   faddr_q  <= wdata_i[23:0];
      if (we_i && addr_i == A_PREFIX) prefix_q <= wdata_i[7:0];
      if (we_i && !lock_q) begin
        if (addr_i == A_MENU_LO) menu_q[31:0]  <= wdata_i;
        if (addr_i == A_MENU_HI) menu_q[63:32] <= wdata_i;
        if (addr_i == A_TYPES)   types_q       <= wdata_i[15:0];
      end
      if (we_i && addr_i == A_LOCK && wdata_i[0]) lock_q <= 1'b1;
      if (we_i && addr_i[4]) begin
        for (int j = 0; j < 4; j++) buf_q[{addr_i[3:0], 2'(j)}] <= wdata_i[8*j +: 8];
      end
      // engine writes win over software
      if (buf_we_i) buf_q[buf_idx_i] <= buf_wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i[4]) begin
      rdata_o = {buf_q[{addr_i[3:0], 2'd3}], buf_q[{addr_i[3:0], 2'd2}],
                 buf_q[{addr_i[3:0], 2'd1}], buf_q[{addr_i[3:0], 2'd0}]};
    end else begin
      case (addr_i)
        A_CTRL:    rdata_o = {16'b0, cmd_q.fast, cmd_q.den, cmd_q.cnt_m1, 1'b0,
                              cmd_q.idx, 1'b0, cmd_q.atom, 2'b0};
        A_STAT:    rdata_o = {29'b0, err_q, done_q, busy_o};
        A_ADDR:    rdata_o = {8'b0, faddr_q};
        A_PREFIX:  rdata_o = {24'b0, prefix_q};
        A_MENU_LO: rdata_o = menu_q[31:0];
        A_MENU_HI: rdata_o = menu_q[63:32];
        A_TYPES:   rdata_o = {16'b0, types_q};
        A_LOCK:    rdata_o = {31'b0, lock_q};
        default:   rdata_o = '0;
      endcase
    end
  end

  assign buf_rdata_o = buf_q[buf_idx_i];
  assign start_o     = start_q;
  assign cmd_o       = cmd_q;
  assign faddr_o     = faddr_q;
  assign prefix_o    = prefix_q;
  assign menu_o      = menu_q;
  assign types_o     = types_q;
  assign done_o      = done_q;
  assign err_o       = err_q;
  assign lock_o      = lock_q;
endmodule

// File: rtl/spi_menu_shift.sv
module spi_menu_shift #(
  parameter int unsigned HW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [7:0]    tx_i,
  input  logic [HW-1:0] half_i,
  input  logic          miso_i,
  output logic          done_o,
  output logic [7:0]    rx_o,
  output logic          sck_o,
  output logic          mosi_o
);
  logic          act_q, sck_q, done_q;
  logic [7:0]    sh_q, rx_q;
  logic [2:0]    bit_q;
  logic [HW-1:0] cnt_q, half_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      sck_q  <= 1'b0;
      done_q <= 1'b0;
      sh_q   <= '0;
      rx_q   <= '0;
      bit_q  <= '0;
      cnt_q  <= '0;
      half_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        act_q  <= 1'b1;
        sck_q  <= 1'b0;
        sh_q   <= tx_i;
        bit_q  <= '0;
        cnt_q  <= '0;
        half_q <= half_i;
      end else if (act_q) begin
        if (cnt_q == half_q - HW'(1)) begin
          cnt_q <= '0;
          if (!sck_q) begin
            sck_q <= 1'b1;
            rx_q  <= {rx_q[6:0], miso_i};
          end else begin
            sck_q <= 1'b0;
            if (bit_q == 3'd7) begin
              act_q  <= 1'b0;
              done_q <= 1'b1;
            end else begin
              bit_q <= bit_q + 3'd1;
              sh_q  <= {sh_q[6:0], 1'b0};
            end
          end
        end else begin
          cnt_q <= cnt_q + HW'(1);
        end
      end
    end
  end

  assign done_o = done_q;
  assign rx_o   = rx_q;
  assign sck_o  = sck_q;
  assign mosi_o = sh_q[7];
endmodule

// File: rtl/spi_menu_seq.sv
module spi_menu_seq
  import spi_menu_pkg::*;
#(
  parameter int unsigned HW        = 2,
  parameter int unsigned HALF_SLOW = 3,
  parameter int unsigned HALF_FAST = 2,
  parameter int unsigned GAP_CLKS  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  cmd_t             cmd_i,
  input  logic [63:0]      menu_i,
  input  logic [15:0]      types_i,
  input  logic [23:0]      faddr_i,
  input  logic [7:0]       prefix_i,
  input  logic             fast_ok_i,
  input  logic [7:0]       buf_rdata_i,
  input  logic             sh_done_i,
  input  logic [7:0]       sh_rx_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             cs_no,
  output logic             sh_start_o,
  output logic [7:0]       sh_tx_o,
  output logic [HW-1:0]    sh_half_o,
  output logic [CNT_W-1:0] buf_idx_o,
  output logic             buf_we_o,
  output logic [7:0]       buf_wdata_o
);
  localparam int unsigned GW = $clog2(GAP_CLKS + 1);

  typedef enum logic [2:0] {S_IDLE, S_LAUNCH, S_WAIT, S_GAP, S_END} state_e;

  state_e           st_q;
  phase_e           ph_q;
  logic [7:0]       op_q, pre_q;
  logic [1:0]       typ_q;
  logic [23:0]      fa_q;
  logic [CNT_W-1:0] cnt_m1_q, idx_q;
  logic             den_q, fast_q, cs_q;
  logic [GW-1:0]    gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= S_IDLE;
      ph_q     <= PH_OP;
      op_q     <= '0;
      pre_q    <= '0;
      typ_q    <= '0;
      fa_q     <= '0;
      cnt_m1_q <= '0;
      idx_q    <= '0;
      den_q    <= 1'b0;
      fast_q   <= 1'b0;
      cs_q     <= 1'b1;
      gap_q    <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (start_i) begin
          op_q     <= menu_i[8*cmd_i.idx +: 8];
          typ_q    <= types_i[2*cmd_i.idx +: 2];
          fa_q     <= faddr_i;
          pre_q    <= prefix_i;
          cnt_m1_q <= cmd_i.cnt_m1;
          den_q    <= cmd_i.den;
          fast_q   <= cmd_i.fast & fast_ok_i;
          ph_q     <= cmd_i.atom ? PH_PRE : PH_OP;
          idx_q    <= '0;
          cs_q     <= 1'b0;
          st_q     <= S_LAUNCH;
        end
        S_LAUNCH: st_q <= S_WAIT;
        S_WAIT: if (sh_done_i) begin
          st_q <= S_LAUNCH;
          case (ph_q)
            PH_PRE: begin
              cs_q  <= 1'b1;
              gap_q <= '0;
              ph_q  <= PH_OP;
              st_q  <= S_GAP;
            end
            PH_OP: begin
              idx_q <= '0;
              if (typ_q[1]) ph_q <= PH_ADDR;
              else if (den_q) ph_q <= PH_DATA;
              else begin cs_q <= 1'b1; st_q <= S_END; end
            end
            PH_ADDR: begin
              if (idx_q == CNT_W'(2)) begin
                idx_q <= '0;
                if (den_q) ph_q <= PH_DATA;
                else begin cs_q <= 1'b1; st_q <= S_END; end
              end else idx_q <= idx_q + CNT_W'(1);
            end
            default: begin
              if (idx_q == cnt_m1_q) begin cs_q <= 1'b1; st_q <= S_END; end
              else idx_q <= idx_q + CNT_W'(1);
            end
          endcase
        end
        S_GAP: begin
          if (gap_q == GW'(GAP_CLKS - 1)) begin
            cs_q <= 1'b0;
            st_q <= S_LAUNCH;
          end else gap_q <= gap_q + GW'(1);
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    case (ph_q)
      PH_PRE:  sh_tx_o = pre_q;
      PH_OP:   sh_tx_o = op_q;
      PH_ADDR: sh_tx_o = (idx_q[1:0] == 2'd0) ? fa_q[23:16] :
                         (idx_q[1:0] == 2'd1) ? fa_q[15:8] : fa_q[7:0];
      default: sh_tx_o = typ_q[0] ? buf_rdata_i : 8'h00;
    endcase
  end

  assign busy_o      = (st_q != S_IDLE);
  assign done_o      = (st_q == S_END);
  assign cs_no       = cs_q;
  assign sh_start_o  = (st_q == S_LAUNCH);
  assign sh_half_o   = fast_q ? HW'(HALF_FAST) : HW'(HALF_SLOW);
  assign buf_idx_o   = idx_q;
  assign buf_we_o    = (st_q == S_WAIT) && sh_done_i && (ph_q == PH_DATA) && !typ_q[0];
  assign buf_wdata_o = sh_rx_i;
endmodule

// File: rtl/spi_menu_engine.sv
module spi_menu_engine
  import spi_menu_pkg::*;
#(
  parameter int unsigned HALF_SLOW = 3,
  parameter int unsigned HALF_FAST = 2,
  parameter int unsigned GAP_CLKS  = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_we_i,
  input  logic [4:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  input  logic        fast_ok_i,
  output logic        sck_o,
  output logic        cs_no,
  output logic        mosi_o,
  input  logic        miso_i
);
  localparam int unsigned HMAX = (HALF_SLOW > HALF_FAST) ? HALF_SLOW : HALF_FAST;
  localparam int unsigned HW   = $clog2(HMAX + 1);

  cmd_t             cmd_w;
  logic             start_w, seq_busy_w, busy_w, done_set_w, done_w, err_w, lock_w;
  logic [23:0]      faddr_w;
  logic [7:0]       prefix_w, buf_rdata_w, buf_wdata_w, sh_tx_w, sh_rx_w;
  logic [63:0]      menu_w;
  logic [15:0]      types_w;
  logic [CNT_W-1:0] buf_idx_w;
  logic             buf_we_w, sh_start_w, sh_done_w;
  logic [HW-1:0]    sh_half_w;

  spi_menu_regs u_regs (
    .clk_i, .rst_ni,
    .we_i        (reg_we_i),
    .addr_i      (reg_addr_i),
    .wdata_i     (reg_wdata_i),
    .rdata_o     (reg_rdata_o),
    .seq_busy_i  (seq_busy_w),
    .done_set_i  (done_set_w),
    .buf_we_i    (buf_we_w),
    .buf_idx_i   (buf_idx_w),
    .buf_wdata_i (buf_wdata_w),
    .buf_rdata_o (buf_rdata_w),
    .start_o     (start_w),
    .cmd_o       (cmd_w),
    .faddr_o     (faddr_w),
    .prefix_o    (prefix_w),
    .menu_o      (menu_w),
    .types_o     (types_w),
    .busy_o      (busy_w),
    .done_o      (done_w),
    .err_o       (err_w),
    .lock_o      (lock_w)
  );

  spi_menu_seq #(
    .HW(HW), .HALF_SLOW(HALF_SLOW), .HALF_FAST(HALF_FAST), .GAP_CLKS(GAP_CLKS)
  ) u_seq (
    .clk_i, .rst_ni,
    .start_i     (start_w),
    .cmd_i       (cmd_w),
    .menu_i      (menu_w),
    .types_i     (types_w),
    .faddr_i     (faddr_w),
    .prefix_i    (prefix_w),
    .fast_ok_i   (fast_ok_i),
    .buf_rdata_i (buf_rdata_w),
    .sh_done_i   (sh_done_w),
    .sh_rx_i     (sh_rx_w),
    .busy_o      (seq_busy_w),
    .done_o      (done_set_w),
    .cs_no       (cs_no),
    .sh_start_o  (sh_start_w),
    .sh_tx_o     (sh_tx_w),
    .sh_half_o   (sh_half_w),
    .buf_idx_o   (buf_idx_w),
    .buf_we_o    (buf_we_w),
    .buf_wdata_o (buf_wdata_w)
  );

  spi_menu_shift #(.HW(HW)) u_shift (
    .clk_i, .rst_ni,
    .start_i (sh_start_w),
    .tx_i    (sh_tx_w),
    .half_i  (sh_half_w),
    .miso_i  (miso_i),
    .done_o  (sh_done_w),
    .rx_o    (sh_rx_w),
    .sck_o   (sck_o),
    .mosi_o  (mosi_o)
  );
endmodule

// File: rtl/spi_menu_checker.sv
module spi_menu_checker
  import spi_menu_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        we_i,
  input logic [4:0]  addr_i,
  input logic [2:0]  wdata_i,
  input logic        cs_no,
  input logic        sck_o,
  input logic        busy_w,
  input logic        done_w,
  input logic        done_set_w,
  input logic        err_w,
  input logic        lock_w,
  input logic [63:0] menu_w,
  input logic [15:0] types_w
);
  a_r2_sck_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sck_o);

  a_r10_select_only_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_no |-> busy_w);

  a_r8_done_at_deselect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_set_w |-> cs_no);

  a_r8_done_w1c: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_STAT && wdata_i[1] && !done_set_w) |=> !done_w);

  a_r9_go_while_busy_errs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == A_CTRL && wdata_i[0] && busy_w) |=> err_w);

  a_r12_locked_tables_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_w && we_i && (addr_i == A_MENU_LO || addr_i == A_MENU_HI || addr_i == A_TYPES))
      |=> ($stable(menu_w) && $stable(types_w)));
endmodule

bind spi_menu_engine spi_menu_checker i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .we_i       (reg_we_i),
  .addr_i     (reg_addr_i),
  .wdata_i    (reg_wdata_i[2:0]),
  .cs_no      (cs_no),
  .sck_o      (sck_o),
  .busy_w     (busy_w),
  .done_w     (done_w),
  .done_set_w (done_set_w),
  .err_w      (err_w),
  .lock_w     (lock_w),
  .menu_w     (menu_w),
  .types_w    (types_w)
);

// File: tb/test_spi_menu_engine.sv
module test_spi_menu_engine;
  import spi_menu_pkg::*;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0, fast_ok = 1'b0, miso = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, rdata;
  logic sck, cs_n, mosi;
  int checks = 0, fails = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  spi_menu_engine i_spi_menu_engine (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(rdata), .fast_ok_i(fast_ok),
    .sck_o(sck), .cs_no(cs_n), .mosi_o(mosi), .miso_i(miso));

  // flash-side capture
  logic [7:0] fr_b [0:7][0:71];
  int fr_len [0:7], fr_gap [0:7], fr_half [0:7];
  int fr_n = 0, cur = 0, bcnt = 0, bitc = 0;
  time t_rise = 0, t_r0 = 0;
  logic [7:0] shreg = '0;

  function automatic logic [7:0] pat(input int k);
    return 8'((k * 37 + 11) & 255);
  endfunction
  function automatic logic [7:0] op(input int i);
    return 8'((8'h30 + i * 17) & 255);
  endfunction

  always @(negedge cs_n) begin
    cur = fr_n; bcnt = 0; bitc = 0;
    if (cur < 8) fr_gap[cur] = int'(($time - t_rise) / CLK_P);
    miso = pat(0)[7];
  end
  always @(posedge cs_n) begin
    if (cur < 8) fr_len[cur] = bcnt;
    fr_n++; t_rise = $time;
  end
  always @(posedge sck) if (cs_n == 1'b0) begin
    if (bcnt == 0 && bitc == 0) t_r0 = $time;
    if (bcnt == 0 && bitc == 1 && cur < 8) fr_half[cur] = int'(($time - t_r0) / (2 * CLK_P));
    shreg = {shreg[6:0], mosi};
    bitc++;
    if (bitc == 8) begin
      if (cur < 8 && bcnt < 72) fr_b[cur][bcnt] = shreg;
      bcnt++; bitc = 0;
    end
  end
  always @(negedge sck) if (cs_n == 1'b0) miso = pat(bcnt)[7 - bitc];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    int n = 0;
    do begin rd(A_STAT, s); n++; end while (s[0] && n < 20000);
  endtask

  task automatic run(input int idx, input int cnt, input bit den, input bit atom, input bit fast);
    fr_n = 0;
    wr(A_CTRL, 32'(1 | (int'(atom) << 2) | (idx << 4) | ((cnt - 1) << 8) |
                   (int'(den) << 14) | (int'(fast) << 15)));
    wait_idle();
  endtask

  function automatic logic [7:0] wpat(input int j, input int s);
    return 8'((j * 13 + s) & 255);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, old;
    int cnts [4] = '{1, 4, 17, 64};
    int bad, t, hdr, n;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 cs", {31'b0, cs_n}, 1);
    check("R1 sck", {31'b0, sck}, 0);
    rd(A_STAT, v); check("R1 status", v, 0);
    rd(A_CTRL, v); check("R1 ctrl", v, 0);
    rst_n = 1'b1;
    @(negedge clk);

    wr(A_MENU_LO, {op(3), op(2), op(1), op(0)});
    wr(A_MENU_HI, {op(7), op(6), op(5), op(4)});
    v = '0;
    for (int i = 0; i < 8; i++) v |= 32'(i % 4) << (2 * i);
    wr(A_TYPES, v);

    // sweep every entry and several counts (R2 R3 R5 R6)
    for (int idx = 0; idx < 8; idx++) begin
      for (int ci = 0; ci < 4; ci++) begin
        n = cnts[ci];
        t = idx % 4;
        hdr = (t >= 2) ? 4 : 1;
        wr(A_ADDR, {8'hE5, 8'(idx * 16 + ci), 8'(ci * 51), 8'(idx + 1)});
        for (int w = 0; w < 16; w++)
          wr(5'(A_BUF0 + w), {wpat(4*w+3, idx*5+ci), wpat(4*w+2, idx*5+ci),
                              wpat(4*w+1, idx*5+ci), wpat(4*w, idx*5+ci)});
        run(idx, n, 1'b1, 1'b0, 1'b0);
        check("R2 frame count", 32'(fr_n), 1);
        check("R2 opcode", {24'b0, fr_b[0][0]}, {24'b0, op(idx)});
        check("R5 frame length", 32'(fr_len[0]), 32'(hdr + n));
        if (t >= 2) begin
          bad = 0;
          if (fr_b[0][1] !== 8'(idx * 16 + ci)) bad++;
          if (fr_b[0][2] !== 8'(ci * 51)) bad++;
          if (fr_b[0][3] !== 8'(idx + 1)) bad++;
          check("R3 address bytes msb first", 32'(bad), 0);
        end
        bad = 0;
        if (t[0]) begin
          for (int j = 0; j < n; j++) if (fr_b[0][hdr + j] !== wpat(j, idx*5+ci)) bad++;
          check("R5 write data order", 32'(bad), 0);
        end else begin
          for (int j = 0; j < n; j++) if (fr_b[0][hdr + j] !== 8'h00) bad++;
          for (int j = 0; j < n; j++) begin
            rd(5'(A_BUF0 + j / 4), v);
            if (v[8*(j%4) +: 8] !== pat(hdr + j)) bad++;
          end
          check("R6 read data into buffer", 32'(bad), 0);
        end
        rd(A_STAT, v); check("R8 done after cycle", v, 32'h2);
        wr(A_STAT, 32'h2);
      end
    end

    // R8 write 0 keeps done, write 1 clears
    run(1, 1, 1'b0, 1'b0, 1'b0);
    wr(A_STAT, 32'h0); rd(A_STAT, v); check("R8 zero write keeps done", v, 32'h2);
    wr(A_STAT, 32'h2); rd(A_STAT, v); check("R8 w1c clears done", v, 32'h0);

    // R7 no data phase
    check("R7 no-address no-data length", 32'(fr_len[0]), 1);
    wr(A_ADDR, 32'hAB123456);
    rd(A_ADDR, v); check("R4 address readback 24 bits", v, 32'h00123456);
    run(3, 5, 1'b0, 1'b0, 1'b0);
    check("R7 address-only length", 32'(fr_len[0]), 4);
    check("R4 address on pins", {8'b0, fr_b[0][1], fr_b[0][2], fr_b[0][3]}, 32'h00123456);
    wr(A_STAT, 32'h2);

    // R9 go while busy
    fr_n = 0;
    wr(A_CTRL, 32'h1 | (3 << 4) | (63 << 8) | (1 << 14));
    repeat (20) @(negedge clk);
    wr(A_CTRL, 32'h1 | (5 << 4));
    rd(A_STAT, v); check("R9 error set, still busy", v, 32'h5);
    wait_idle();
    check("R9 no extra frame", 32'(fr_n), 1);
    check("R9 original opcode", {24'b0, fr_b[0][0]}, {24'b0, op(3)});
    rd(A_CTRL, v); check("R9 control unchanged", v, 32'((3 << 4) | (63 << 8) | (1 << 14)));
    wr(A_STAT, 32'h6); rd(A_STAT, v); check("R8 w1c clears error", v, 0);

    // R10 atomic prefix
    wr(A_PREFIX, 32'h06);
    run(3, 2, 1'b1, 1'b1, 1'b0);
    check("R10 two frames", 32'(fr_n), 2);
    check("R10 prefix frame length", 32'(fr_len[0]), 1);
    check("R10 prefix byte", {24'b0, fr_b[0][0]}, 32'h06);
    check("R10 gap at least 2", 32'(fr_gap[1] >= 2), 1);
    check("R10 main opcode", {24'b0, fr_b[1][0]}, {24'b0, op(3)});
    check("R10 main length", 32'(fr_len[1]), 6);
    wr(A_STAT, 32'h2);

    // R11 speed select
    fast_ok = 1'b1; run(1, 1, 1'b0, 1'b0, 1'b1);
    check("R11 fast permitted", 32'(fr_half[0]), 2);
    fast_ok = 1'b0; run(1, 1, 1'b0, 1'b0, 1'b1);
    check("R11 fast blocked", 32'(fr_half[0]), 3);
    fast_ok = 1'b1; run(1, 1, 1'b0, 1'b0, 1'b0);
    check("R11 slow selected", 32'(fr_half[0]), 3);
    wr(A_STAT, 32'h2);

    // R12 lock
    rd(A_MENU_LO, old);
    wr(A_LOCK, 32'h1);
    rd(A_LOCK, v); check("R12 lock set", v, 1);
    wr(A_MENU_LO, 32'hDEADBEEF);
    rd(A_MENU_LO, v); check("R12 menu held", v, old);
    wr(A_TYPES, 32'h0000FFFF);
    rd(A_TYPES, v); check("R12 types held", v, 32'h0000E4E4);
    run(0, 1, 1'b0, 1'b0, 1'b0);
    check("R12 old opcode issued", {24'b0, fr_b[0][0]}, {24'b0, op(0)});

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule